// File: doc/BRIEF.md
# USB Transceiver Mode and Clock-Setup Sequencer

This block sits on the host side of an external USB transceiver. It owns the transceiver's two active-low mode lines, a chip select and a reset. The static levels of these two lines choose the transceiver's operating state: sleep, normal, tristated interface outputs, or clock configuration. A requester issues a one-cycle strobe with a target mode. When that target is configuration, the requester also gives a 3-bit clock option. The block then drives the lines through a timed sequence and reports busy, done and error.

Some transitions are not allowed to go straight to their target. When a change is requested between two different non-normal states, the block first parks the transceiver in normal mode. The configuration sequence runs in three parts. The block raises chip select and holds reset low to enter configuration. It then sends a burst of reset pulses whose count is the clock option. Finally it drops chip select, which leaves the transceiver in normal mode. All hold times and pulse widths are parameters counted in system clock cycles. A variant parameter selects a reduced-pin transceiver that has no crystal oscillator, and for that variant the crystal options are refused.

Top module: `phy_mode_seq`

## Requirements
- R1: While the system reset is asserted and after it is released, both mode lines are low (sleep), and busy, done and error are low.
- R2: Line levels {phy_cs_no, phy_rst_no} are: sleep 00, normal 01, tristate 11, configuration 10. Request codes on req_mode_i are: 0 sleep, 1 normal, 2 tristate, 3 configure. When a request completes, the lines show the requested mode, and a configure request ends in normal.
- R3: A request that moves between two different levels, neither of them normal, first drives normal and then the target. Every level the block drives is held for at least T_STATE cycles, except for the pulse phases.
- R4: A configure request drives the configuration level (chip select high, reset low) for at least T_STATE cycles before the first reset pulse.
- R5: During configuration the block sends exactly as many reset high pulses as the clock option value (0 to 7, where 0 sends none). Chip select stays high throughout. Each pulse is high for at least PULSE_HI cycles and low for at least PULSE_LO cycles.
- R6: After the last pulse the block drops chip select with reset high (normal) and holds that level for at least T_STATE cycles before it returns to idle.
- R7: busy is high from the cycle after an accepted request until completion. Completion is marked by a single-cycle done, in the same cycle that busy falls.
- R8: A request that arrives while busy produces a single-cycle error in the following cycle. The sequence in progress continues unchanged.
- R9: With REDUCED_PIN set, a configure request with option 4 to 7 produces a single-cycle error and is not started: the lines and busy do not change. Options 0 to 3 are still accepted.
- R10: A request for the mode already on the lines leaves the lines unchanged, holds for T_STATE cycles, and completes with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous system reset |
| req_i | input | 1 | One-cycle request strobe |
| req_mode_i | input | 2 | Target mode code (see R2) |
| req_opt_i | input | 3 | Clock option, used by configure requests |
| phy_cs_no | output | 1 | Active-low chip select to the transceiver |
| phy_rst_no | output | 1 | Active-low reset to the transceiver |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
The bench records every level change on the two lines and how long each level is held. It compares the result with a sequence that it builds from the request and the starting level, so a design that skipped the stop in normal, for example going from tristate straight to sleep, would show a missing segment. The bench covers option 0 and option 7. A design with an off-by-one pulse counter would send one pulse too many or too few, and a design that shortened a hold would show a segment below its minimum. It also injects a request in the middle of a long sequence, which catches a design that aborts or restarts on a request while busy. On the reduced-pin instance, a design that started crystal options would drive the lines or raise busy.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;

   localparam int unsigned OPT_W = 3;

   typedef enum logic [1:0] {
      REQ_SLEEP    = 2'd0,
      REQ_NORMAL   = 2'd1,
      REQ_TRISTATE = 2'd2,
      REQ_CONFIG   = 2'd3
   } req_mode_e;

   // bit 1 = chip select (active low), bit 0 = reset (active low)
   typedef logic [1:0] line_lvl_t;

   localparam line_lvl_t LVL_SLEEP    = 2'b00;
   localparam line_lvl_t LVL_NORMAL   = 2'b01;
   localparam line_lvl_t LVL_CONFIG   = 2'b10;
   localparam line_lvl_t LVL_TRISTATE = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_VIA_NORMAL,
      ST_TARGET,
      ST_CFG_ENTER,
      ST_PULSE_HI,
      ST_PULSE_LO,
      ST_CFG_EXIT
   } seq_state_e;

   function automatic line_lvl_t level_of_mode(req_mode_e m);
      line_lvl_t l;
      unique case (m)
         REQ_SLEEP:    l = LVL_SLEEP;
         REQ_NORMAL:   l = LVL_NORMAL;
         REQ_TRISTATE: l = LVL_TRISTATE;
         default:      l = LVL_CONFIG;
      endcase
      return l;
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/phy_mode_timer.sv
module phy_mode_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          expired_o
);

   if (CW < 1) begin : g_bad_cw
      $error("phy_mode_timer: CW must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

   // R3: an idle timer stays expired until it is reloaded
   p_timer_rest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/phy_mode_pulse_cnt.sv
module phy_mode_pulse_cnt #(
   parameter int unsigned OW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [OW-1:0] load_val_i,
   input  logic          dec_i,
   output logic          zero_o
);

   logic [OW-1:0] left_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         left_q <= '0;
      end else if (load_i) begin
         left_q <= load_val_i;
      end else if (dec_i) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign zero_o = (left_q == '0);

   // R5: never emit more pulses than requested
   p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec_i |-> !zero_o);

endmodule

// File: rtl/phy_mode_req_check.sv
module phy_mode_req_check
   import phy_mode_pkg::*;
#(
   parameter bit REDUCED_PIN = 1'b0
) (
   input  req_mode_e        mode_i,
   input  logic [OPT_W-1:0] opt_i,
   output logic             ok_o
);

   localparam int unsigned NUM_OPT_FULL = 2 ** OPT_W;
   localparam int unsigned NUM_OPT_RED  = NUM_OPT_FULL / 2;

   logic opt_ok;

   if (REDUCED_PIN) begin : g_reduced
      assign opt_ok = ({1'b0, opt_i} < (OPT_W + 1)'(NUM_OPT_RED));
   end else begin : g_full
      assign opt_ok = 1'b1;
   end

   assign ok_o = (mode_i != REQ_CONFIG) || opt_ok;

endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
   import phy_mode_pkg::*;
#(
   parameter int unsigned T_STATE     = 16,
   parameter int unsigned PULSE_HI    = 4,
   parameter int unsigned PULSE_LO    = 4,
   parameter bit          REDUCED_PIN = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       req_i,
   input  logic [1:0] req_mode_i,
   input  logic [2:0] req_opt_i,
   output logic       phy_cs_no,
   output logic       phy_rst_no,
   output logic       busy_o,
   output logic       done_o,
   output logic       err_o
);

   localparam int unsigned WMAX = max3(T_STATE, PULSE_HI, PULSE_LO);
   localparam int unsigned TW   = (WMAX < 2) ? 1 : $clog2(WMAX + 1);
   localparam logic [TW-1:0] LD_STATE = TW'(T_STATE - 1);
   localparam logic [TW-1:0] LD_HI    = TW'(PULSE_HI - 1);
   localparam logic [TW-1:0] LD_LO    = TW'(PULSE_LO - 1);

   if (T_STATE < 1 || PULSE_HI < 1 || PULSE_LO < 1) begin : g_bad_width
      $error("phy_mode_seq: all hold widths must be at least one cycle");
   end
   if (OPT_W != 3) begin : g_bad_opt
      $error("phy_mode_seq: clock option must be three bits");
   end

   seq_state_e state_q, nxt_state;
   line_lvl_t  lvl_q, nxt_lvl, req_tgt;
   req_mode_e  mode_q, mode_in;
   logic       done_q, err_q, done_set, accept;
   logic       tmr_load, tmr_done;
   logic [TW-1:0] tmr_val;
   logic       cnt_load, cnt_dec, cnt_zero;
   logic       req_ok, busy;

   assign mode_in = req_mode_e'(req_mode_i);
   assign req_tgt = level_of_mode(mode_in);
   assign busy    = (state_q != ST_IDLE);

   phy_mode_req_check #(.REDUCED_PIN(REDUCED_PIN)) u_check (
      .mode_i (mode_in),
      .opt_i  (req_opt_i),
      .ok_o   (req_ok)
   );

   phy_mode_timer #(.CW(TW)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_done)
   );

   phy_mode_pulse_cnt #(.OW(OPT_W)) u_pulses (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cnt_load),
      .load_val_i (req_opt_i),
      .dec_i      (cnt_dec),
      .zero_o     (cnt_zero)
   );

   always_comb begin
      nxt_state = state_q;
      nxt_lvl   = lvl_q;
      tmr_load  = 1'b0;
      tmr_val   = LD_STATE;
      cnt_load  = 1'b0;
      cnt_dec   = 1'b0;
      done_set  = 1'b0;
      accept    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i && req_ok) begin
               accept   = 1'b1;
               cnt_load = 1'b1;
               tmr_load = 1'b1;
               if (lvl_q != LVL_NORMAL && req_tgt != LVL_NORMAL && req_tgt != lvl_q) begin
                  nxt_state = ST_VIA_NORMAL;
                  nxt_lvl   = LVL_NORMAL;
               end else if (mode_in == REQ_CONFIG) begin
                  nxt_state = ST_CFG_ENTER;
                  nxt_lvl   = LVL_CONFIG;
               end else begin
                  nxt_state = ST_TARGET;
                  nxt_lvl   = req_tgt;
               end
            end
         end
         ST_VIA_NORMAL: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               if (mode_q == REQ_CONFIG) begin
                  nxt_state = ST_CFG_ENTER;
                  nxt_lvl   = LVL_CONFIG;
               end else begin
                  nxt_state = ST_TARGET;
                  nxt_lvl   = level_of_mode(mode_q);
               end
            end
         end
         ST_CFG_ENTER, ST_PULSE_LO: begin
            if (tmr_done) begin
               tmr_load = 1'b1;
               if (cnt_zero) begin
                  nxt_state = ST_CFG_EXIT;
                  nxt_lvl   = LVL_NORMAL;
               end else begin
                  nxt_state = ST_PULSE_HI;
                  nxt_lvl   = LVL_TRISTATE;
                  tmr_val   = LD_HI;
               end
            end
         end
         ST_PULSE_HI: begin
            if (tmr_done) begin
               tmr_load  = 1'b1;
               tmr_val   = LD_LO;
               cnt_dec   = 1'b1;
               nxt_state = ST_PULSE_LO;
               nxt_lvl   = LVL_CONFIG;
            end
         end
         ST_TARGET, ST_CFG_EXIT: begin
            if (tmr_done) begin
               nxt_state = ST_IDLE;
               done_set  = 1'b1;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         lvl_q   <= LVL_SLEEP;
         mode_q  <= REQ_SLEEP;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= nxt_state;
         lvl_q   <= nxt_lvl;
         done_q  <= done_set;
         err_q   <= req_i && (busy || !req_ok);
         if (accept) begin
            mode_q <= mode_in;
         end
      end
   end

   assign phy_cs_no  = lvl_q[1];
   assign phy_rst_no = lvl_q[0];
   assign busy_o     = busy;
   assign done_o     = done_q;
   assign err_o      = err_q;

   // R3: leaving sleep always lands in normal
   p_sleep_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lvl_q) == LVL_SLEEP && lvl_q != LVL_SLEEP) |-> lvl_q == LVL_NORMAL);

   // R3: leaving a settled tristate always lands in normal
   p_tri_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(lvl_q) == LVL_TRISTATE && $past(state_q) == ST_IDLE && lvl_q != LVL_TRISTATE)
      |-> lvl_q == LVL_NORMAL);

   // R6: configuration level is never left standing when idle
   p_idle_no_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> {phy_cs_no, phy_rst_no} != LVL_CONFIG);

   // R7: done lasts one cycle and coincides with busy low
   p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o);

   // R8: request while busy is flagged
   p_busy_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && busy_o) |=> err_o);

   // R9: a refused option leaves lines and busy alone
   p_bad_opt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !busy_o && !req_ok) |=> (err_o && !busy_o && $stable(lvl_q)));

endmodule

// File: tb/test_phy_mode_seq.sv
module test_phy_mode_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TS = 5;
   localparam int TH = 2;
   localparam int TL = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req2 = 1'b0;
   logic [1:0] mode = '0, mode2 = '0;
   logic [2:0] opt = '0, opt2 = '0;
   logic cs, rs, busy, done, err;
   logic cs2, rs2, busy2, done2, err2;

   always #(CLK_PERIOD / 2) clk = ~clk;

   phy_mode_seq #(.T_STATE(TS), .PULSE_HI(TH), .PULSE_LO(TL), .REDUCED_PIN(1'b0)) i_phy_mode_seq (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_mode_i(mode), .req_opt_i(opt),
      .phy_cs_no(cs), .phy_rst_no(rs), .busy_o(busy), .done_o(done), .err_o(err));

   phy_mode_seq #(.T_STATE(TS), .PULSE_HI(TH), .PULSE_LO(TL), .REDUCED_PIN(1'b1)) i_phy_mode_seq_rp (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req2), .req_mode_i(mode2), .req_opt_i(opt2),
      .phy_cs_no(cs2), .phy_rst_no(rs2), .busy_o(busy2), .done_o(done2), .err_o(err2));

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int exp_lv[64];
   int exp_min[64];
   int exp_n;
   int obs_lv[64];
   int obs_len[64];
   int obs_n;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // level code {cs_n, rst_n}: sleep 0, normal 1, config 2, tristate 3
   function automatic int lvl_of(input int m);
      case (m)
         0: return 0;
         1: return 1;
         2: return 3;
         default: return 2;
      endcase
   endfunction

   task automatic push_exp(input int l, input int w);
      exp_lv[exp_n]  = l;
      exp_min[exp_n] = w;
      exp_n++;
   endtask

   task automatic build_exp(input int m, input int o, input int start);
      int tgt;
      exp_n = 0;
      tgt = lvl_of(m);
      if (start != 1 && tgt != 1 && tgt != start) push_exp(1, TS);
      if (m == 3) begin
         push_exp(2, TS);
         for (int i = 0; i < o; i++) begin
            push_exp(3, TH);
            push_exp(2, TL);
         end
         push_exp(1, TS);
      end else if (tgt != start) begin
         push_exp(tgt, TS);
      end
   endtask

   task automatic run_req(input int m, input int o, input int inj, input string tag);
      int start, cur, l, fin, hold;
      bit got_done;
      string stag;
      @(negedge clk);
      start = int'({cs, rs});
      req = 1'b1; mode = m[1:0]; opt = o[2:0];
      build_exp(m, o, start);
      obs_n = 0; cur = start; got_done = 1'b0; hold = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (k == 0) begin
            req = 1'b0;
            chk(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
         end
         if (done) begin
            got_done = 1'b1;
            break;
         end
         l = int'({cs, rs});
         if (l != cur) begin
            if (obs_n < 64) begin
               obs_lv[obs_n] = l;
               obs_len[obs_n] = 1;
               obs_n++;
            end
            cur = l;
         end else if (obs_n > 0) begin
            obs_len[obs_n-1]++;
         end else begin
            hold++;
         end
         if (inj > 0 && k == inj) begin
            req = 1'b1; mode = 2'd0;
         end else if (inj > 0 && k == inj + 1) begin
            req = 1'b0;
            chk(err == 1'b1, "R8", "error for request while busy", int'(err), 1);
         end
      end
      chk(got_done, tag, "done seen", int'(got_done), 1);
      chk(busy == 1'b0, "R7", "busy low with done", int'(busy), 0);
      chk(obs_n == exp_n, tag, "number of level changes", obs_n, exp_n);
      for (int i = 0; i < obs_n && i < exp_n; i++) begin
         if (exp_lv[i] == 3 && m == 3) stag = "R5";
         else if (exp_lv[i] == 2) stag = "R4";
         else if (m == 3 && i == exp_n - 1) stag = "R6";
         else stag = tag;
         chk(obs_lv[i] == exp_lv[i], stag, "level in sequence", obs_lv[i], exp_lv[i]);
         chk(obs_len[i] >= exp_min[i], stag, "level hold length", obs_len[i], exp_min[i]);
      end
      if (exp_n == 0) chk(hold >= TS, "R10", "same-mode hold", hold, TS);
      fin = (m == 3) ? 1 : lvl_of(m);
      chk(int'({cs, rs}) == fin, "R2", "final line level", int'({cs, rs}), fin);
      @(negedge clk);
      chk(done == 1'b0, "R7", "done lasts one cycle", int'(done), 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int pulses, prev;
      bit seen;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk({cs, rs} == 2'b00, "R1", "lines in reset", int'({cs, rs}), 0);
      chk({busy, done, err} == 3'b000, "R1", "status in reset", int'({busy, done, err}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({cs, rs, busy, done, err} == 5'b0, "R1", "state after reset", int'({cs, rs, busy, done, err}), 0);
      chk({cs2, rs2, busy2} == 3'b0, "R1", "reduced state after reset", int'({cs2, rs2, busy2}), 0);

      run_req(0, 0, -1, "R10");
      run_req(2, 0, -1, "R3");
      run_req(3, 0, -1, "R5");
      run_req(3, 7, 3, "R8");
      run_req(2, 0, -1, "R3");
      run_req(0, 0, -1, "R3");
      run_req(2, 0, -1, "R3");
      run_req(2, 0, -1, "R10");
      for (int n = 0; n < 40; n++) begin
         run_req(int'($urandom % 4), int'($urandom % 8), -1, "R3");
      end

      // reduced-pin variant: crystal option refused
      @(negedge clk);
      req2 = 1'b1; mode2 = 2'd3; opt2 = 3'd5;
      @(negedge clk);
      req2 = 1'b0;
      chk(err2 == 1'b1, "R9", "crystal option rejected", int'(err2), 1);
      chk(busy2 == 1'b0, "R9", "no start on reject", int'(busy2), 0);
      chk({cs2, rs2} == 2'b00, "R9", "lines unchanged on reject", int'({cs2, rs2}), 0);
      @(negedge clk);
      chk(err2 == 1'b0, "R9", "error lasts one cycle", int'(err2), 0);
      chk({cs2, rs2} == 2'b00, "R9", "lines still unchanged", int'({cs2, rs2}), 0);

      // reduced-pin variant: clock-input option accepted
      req2 = 1'b1; mode2 = 2'd3; opt2 = 3'd2;
      @(negedge clk);
      req2 = 1'b0;
      chk(busy2 == 1'b1, "R9", "allowed option starts", int'(busy2), 1);
      pulses = 0; prev = int'(rs2); seen = 1'b0;
      for (int k = 0; k < 300; k++) begin
         if (done2) begin
            seen = 1'b1;
            break;
         end
         if (cs2 && rs2 && prev == 0) pulses++;
         prev = int'(rs2);
         @(negedge clk);
      end
      chk(seen, "R9", "reduced done seen", int'(seen), 1);
      chk(pulses == 2, "R5", "reduced pulse count", pulses, 2);
      chk({cs2, rs2} == 2'b01, "R6", "reduced ends normal", int'({cs2, rs2}), 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule